// File: doc/BRIEF.md
# Tile-Parallel Line Hough Voting Engine

This block builds the line-parameter vote space of a binary edge map. The image is cut into a grid of equal tiles, and every tile feeds one pixel per beat, with all tiles at the same position inside their tile. A frame therefore takes one beat per pixel of a single tile instead of one beat per pixel of the whole image. For each quantised angle, one table shared by all tiles gives the distance term of the current in-tile position. Each tile adds the constant distance term of its own tile origin to form the full-image distance, and then rounds the result to a bin. The votes that all tiles cast in one beat are summed per bin and added, with saturation, into one accumulator per angle. The final space is identical to the one a pixel-by-pixel transform of the whole image would produce.

Software or a downstream peak finder pulses `start_i` and streams the tile-parallel beats. It waits for `done_o` and then reads any (angle, bin) counter through the combinational read port. Image width and height, and the tile counts along each axis, are separate parameters, so rectangular images are covered. The default is a 16 by 16 image on an 8 by 8 grid, with four angles and a bin width of four pixels.

Top module: `hough_grid_voter`

## Requirements
- R1: After reset `done_o` is low and every read of the accumulator returns 0.
- R2: A `start_i` pulse while idle clears every bin and opens a frame of TILE_W*TILE_H beats. Valid beat n carries in-tile position lx = n mod TILE_W and ly = n div TILE_W. Bit t of `pix_edge_i` belongs to tile column t mod GRID_X and tile row t div GRID_X. Its image pixel is x = column*TILE_W + lx, y = row*TILE_H + ly.
- R3: Angle a is a*180/N_ANG degrees, with coefficients C = round(256*cos) and S = round(256*sin). A pixel with edge bit 1 adds one vote, in every angle, to bin floor((x*C + y*S + IMG_W*256 + 2^(7+BIN_LOG2)) / 2^(8+BIN_LOG2)). The result equals a serial transform of the whole image.
- R4: Votes from several tiles that hit the same bin in the same beat are all counted.
- R5: A bin counter stops at 2^CNT_W - 1 and never wraps.
- R6: Beats with `pix_valid_i` low, and beats offered while no frame is open, cast no votes.
- R7: `done_o` is a one-cycle pulse. It is low in the cycle after the one that carries the last beat and high in the cycle after that. From then until the next start, reads return the final counts.
- R8: A `start_i` pulse while a frame is being collected or drained has no effect.
- R9: A read with a bin index of N_RHO or more returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a frame and clears the vote space |
| pix_valid_i | input | 1 | The current beat carries pixels |
| pix_edge_i | input | GRID_X*GRID_Y | Edge bit of each tile at the current in-tile position |
| rd_ang_i | input | ANG_W | Angle index to read |
| rd_rho_i | input | IDX_W | Distance bin to read |
| done_o | output | 1 | One-cycle pulse when the vote space is complete |
| rd_cnt_o | output | CNT_W | Vote count of the selected bin |

## Verification
A wrong origin term or a wrong table entry moves votes for a whole tile or a whole in-tile position into a neighbouring bin. This shows as a pair of bins, one too high and one too low, in the read-back after the first `done_o`. A lost same-bin collision shows only where tiles agree, which the full and line images force. A wrapping counter reads a small value instead of the ceiling in the full image. A pixel counter off by one moves the `done_o` pulse by a cycle and shifts every later vote to a different position, so both the pulse-timing check and most bins fail in that same frame.

// File: rtl/hv_pkg.sv
package hv_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_DRAIN = 2'd2
   } hv_state_e;

   localparam real HV_PI = 3.14159265358979323846;

   function automatic int q8_round(real v);
      real s;
      s = 256.0 * v;
      if (s >= 0.0) return $rtoi(s + 0.5);
      return -$rtoi(-s + 0.5);
   endfunction

   function automatic int cos_q8(int a, int n);
      return q8_round($cos(HV_PI * a / n));
   endfunction

   function automatic int sin_q8(int a, int n);
      return q8_round($sin(HV_PI * a / n));
   endfunction

   function automatic int width_of(int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/hv_rho_lut.sv
module hv_rho_lut #(
   parameter int TILE_W = 2,
   parameter int TILE_H = 2,
   parameter int COS_Q8 = 256,
   parameter int SIN_Q8 = 0,
   parameter int RQ_W   = 16,
   parameter int SPLIT  = 1,
   localparam int LX_W  = hv_pkg::width_of(TILE_W),
   localparam int LY_W  = hv_pkg::width_of(TILE_H)
) (
   input  logic [LX_W-1:0]          lx_i,
   input  logic [LY_W-1:0]          ly_i,
   output logic signed [RQ_W-1:0]   rho_o
);

   if (SPLIT != 0) begin : g_split
      // condensed table: one column term per lx, one row term per ly
      logic signed [RQ_W-1:0] xtab [TILE_W];
      logic signed [RQ_W-1:0] ytab [TILE_H];
      for (genvar i = 0; i < TILE_W; i++) begin : g_x
         assign xtab[i] = RQ_W'(i * COS_Q8);
      end
      for (genvar j = 0; j < TILE_H; j++) begin : g_y
         assign ytab[j] = RQ_W'(j * SIN_Q8);
      end
      assign rho_o = xtab[lx_i] + ytab[ly_i];
   end else begin : g_full
      localparam int N_ENT = TILE_W * TILE_H;
      localparam int LI_W  = hv_pkg::width_of(N_ENT);
      logic signed [RQ_W-1:0] tab [N_ENT];
      logic [LI_W-1:0]        li;
      for (genvar i = 0; i < N_ENT; i++) begin : g_e
         assign tab[i] = RQ_W'((i % TILE_W) * COS_Q8 + (i / TILE_W) * SIN_Q8);
      end
      assign li    = LI_W'(32'(ly_i) * TILE_W + 32'(lx_i));
      assign rho_o = tab[li];
   end

endmodule

// File: rtl/hv_tile_bin.sv
module hv_tile_bin #(
   parameter int RQ_W    = 16,
   parameter int IDX_W   = 4,
   parameter int N_RHO   = 13,
   parameter int ORG_Q8  = 0,
   parameter int BIAS_Q8 = 4608,
   parameter int SHIFT   = 10
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    en_i,
   input  logic                    edge_i,
   input  logic signed [RQ_W-1:0]  rho_loc_i,
   output logic [IDX_W-1:0]        idx_o,
   output logic                    vote_o
);

   logic signed [RQ_W-1:0] rho_glb;
   logic signed [RQ_W-1:0] biased;

   // two-operand add of the tile origin term, then offset and half-bin
   assign rho_glb = rho_loc_i + RQ_W'(ORG_Q8);
   assign biased  = rho_glb + RQ_W'(BIAS_Q8);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         vote_o <= 1'b0;
         idx_o  <= '0;
      end else begin
         vote_o <= en_i & edge_i;
         if (en_i) idx_o <= biased[SHIFT +: IDX_W];
      end
   end

   p_bin_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i |-> (biased >= 0) && (32'(biased >>> SHIFT) < N_RHO));

endmodule

// File: rtl/hv_merge_acc.sv
module hv_merge_acc #(
   parameter int N_TILES = 64,
   parameter int N_RHO   = 13,
   parameter int IDX_W   = 4,
   parameter int CNT_W   = 6,
   localparam int SUM_W  = $clog2(N_TILES + 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clr_i,
   input  logic              vote_i [N_TILES],
   input  logic [IDX_W-1:0]  idx_i  [N_TILES],
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic [CNT_W-1:0]  rd_cnt_o
);

   localparam int NW = CNT_W + SUM_W;
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] acc_view [N_RHO];

   for (genvar b = 0; b < N_RHO; b++) begin : g_bin
      logic [SUM_W-1:0] hits;
      logic [NW-1:0]    nxt;
      logic [CNT_W-1:0] acc_q;

      // merge of all tile votes for this bin in one beat
      always_comb begin
         hits = '0;
         for (int t = 0; t < N_TILES; t++)
            hits = hits + SUM_W'(vote_i[t] && (32'(idx_i[t]) == b));
      end

      assign nxt = NW'(acc_q) + NW'(hits);

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                   acc_q <= '0;
         else if (clr_i)                acc_q <= '0;
         else if (nxt > NW'(CNT_MAX))   acc_q <= CNT_MAX;
         else                           acc_q <= nxt[CNT_W-1:0];
      end

      assign acc_view[b] = acc_q;

      p_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
         clr_i |=> acc_q == '0);
      p_no_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !clr_i |=> acc_q >= $past(acc_q));
      p_sat_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (acc_q == CNT_MAX) && !clr_i |=> acc_q == CNT_MAX);
   end

   assign rd_cnt_o = (32'(rd_idx_i) < N_RHO) ? acc_view[rd_idx_i] : '0;

endmodule

// File: rtl/hough_grid_voter.sv
module hough_grid_voter #(
   parameter int IMG_W     = 16,
   parameter int IMG_H     = 16,
   parameter int GRID_X    = 8,
   parameter int GRID_Y    = 8,
   parameter int N_ANG     = 4,
   parameter int BIN_LOG2  = 2,
   parameter int CNT_W     = 6,
   parameter int LUT_SPLIT = 1,
   localparam int N_TILES  = GRID_X * GRID_Y,
   localparam int N_RHO    = ((2 * IMG_W + IMG_H) >> BIN_LOG2) + 1,
   localparam int IDX_W    = hv_pkg::width_of(N_RHO),
   localparam int ANG_W    = hv_pkg::width_of(N_ANG)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               start_i,
   input  logic               pix_valid_i,
   input  logic [N_TILES-1:0] pix_edge_i,
   input  logic [ANG_W-1:0]   rd_ang_i,
   input  logic [IDX_W-1:0]   rd_rho_i,
   output logic               done_o,
   output logic [CNT_W-1:0]   rd_cnt_o
);

   localparam int TILE_W = IMG_W / GRID_X;
   localparam int TILE_H = IMG_H / GRID_Y;
   localparam int LX_W   = hv_pkg::width_of(TILE_W);
   localparam int LY_W   = hv_pkg::width_of(TILE_H);
   localparam int RQ_W   = $clog2((2 * IMG_W + IMG_H + 2) << 9) + 1;
   localparam int SHIFT  = 8 + BIN_LOG2;
   localparam int BIAS   = IMG_W * 256 + (1 << (SHIFT - 1));

   if (IMG_W % GRID_X != 0 || IMG_H % GRID_Y != 0) begin : g_bad_grid
      $error("image size must be a multiple of the tile grid");
   end
   if (N_ANG < 2 || CNT_W < 2 || BIN_LOG2 < 0) begin : g_bad_opt
      $error("need two or more angles, CNT_W >= 2, BIN_LOG2 >= 0");
   end

   hv_pkg::hv_state_e state_q;
   logic [LX_W-1:0]   lx_q;
   logic [LY_W-1:0]   ly_q;
   logic              beat, last_beat, clr;
   logic              s1_last_q, done_q;

   assign beat      = (state_q == hv_pkg::ST_RUN) && pix_valid_i;
   assign last_beat = beat && (lx_q == LX_W'(TILE_W - 1)) && (ly_q == LY_W'(TILE_H - 1));
   assign clr       = (state_q == hv_pkg::ST_IDLE) && start_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q   <= hv_pkg::ST_IDLE;
         lx_q      <= '0;
         ly_q      <= '0;
         s1_last_q <= 1'b0;
         done_q    <= 1'b0;
      end else begin
         s1_last_q <= last_beat;
         done_q    <= s1_last_q;
         unique case (state_q)
            hv_pkg::ST_IDLE: if (start_i) begin
               state_q <= hv_pkg::ST_RUN;
               lx_q    <= '0;
               ly_q    <= '0;
            end
            hv_pkg::ST_RUN: if (beat) begin
               if (lx_q == LX_W'(TILE_W - 1)) begin
                  lx_q <= '0;
                  ly_q <= ly_q + 1'b1;
               end else begin
                  lx_q <= lx_q + 1'b1;
               end
               if (last_beat) state_q <= hv_pkg::ST_DRAIN;
            end
            hv_pkg::ST_DRAIN: if (s1_last_q) state_q <= hv_pkg::ST_IDLE;
            default: state_q <= hv_pkg::ST_IDLE;
         endcase
      end
   end

   assign done_o = done_q;

   logic [CNT_W-1:0] cnt_ang [N_ANG];

   for (genvar a = 0; a < N_ANG; a++) begin : g_ang
      localparam int C = hv_pkg::cos_q8(a, N_ANG);
      localparam int S = hv_pkg::sin_q8(a, N_ANG);
      logic signed [RQ_W-1:0] rho_loc;
      logic [IDX_W-1:0]       idx  [N_TILES];
      logic                   vote [N_TILES];

      hv_rho_lut #(
         .TILE_W(TILE_W), .TILE_H(TILE_H), .COS_Q8(C), .SIN_Q8(S),
         .RQ_W(RQ_W), .SPLIT(LUT_SPLIT)
      ) u_lut (
         .lx_i(lx_q), .ly_i(ly_q), .rho_o(rho_loc)
      );

      for (genvar t = 0; t < N_TILES; t++) begin : g_tile
         localparam int ORG = (t % GRID_X) * TILE_W * C + (t / GRID_X) * TILE_H * S;
         hv_tile_bin #(
            .RQ_W(RQ_W), .IDX_W(IDX_W), .N_RHO(N_RHO),
            .ORG_Q8(ORG), .BIAS_Q8(BIAS), .SHIFT(SHIFT)
         ) u_bin (
            .clk_i(clk_i), .rst_ni(rst_ni), .en_i(beat), .edge_i(pix_edge_i[t]),
            .rho_loc_i(rho_loc), .idx_o(idx[t]), .vote_o(vote[t])
         );
      end

      hv_merge_acc #(
         .N_TILES(N_TILES), .N_RHO(N_RHO), .IDX_W(IDX_W), .CNT_W(CNT_W)
      ) u_acc (
         .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr),
         .vote_i(vote), .idx_i(idx),
         .rd_idx_i(rd_rho_i), .rd_cnt_o(cnt_ang[a])
      );
   end

   assign rd_cnt_o = (32'(rd_ang_i) < N_ANG) ? cnt_ang[rd_ang_i] : '0;

   p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);
   p_done_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      last_beat |=> !done_o);
   p_start_run_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == hv_pkg::ST_RUN) && start_i && !pix_valid_i |=> $stable(lx_q) && $stable(ly_q));
   p_start_drain_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == hv_pkg::ST_DRAIN) && start_i |=> state_q != hv_pkg::ST_RUN);
   p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == hv_pkg::ST_IDLE) && !start_i |=> $stable(lx_q) && $stable(ly_q));

endmodule

// File: tb/hough_grid_voter_tb.sv
module hough_grid_voter_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int W  = 16;
   localparam int H  = 16;
   localparam int GX = 8;
   localparam int GY = 8;
   localparam int NA = 4;
   localparam int BL = 2;
   localparam int CW = 6;
   localparam int TW = W / GX;
   localparam int TH = H / GY;
   localparam int NT = GX * GY;
   localparam int NR = ((2 * W + H) >> BL) + 1;
   localparam int CMAX = (1 << CW) - 1;
   localparam real PI = 3.14159265358979323846;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          pv = 1'b0;
   logic [NT-1:0] pe = '0;
   logic [1:0]    rd_ang = '0;
   logic [3:0]    rd_rho = '0;
   logic          done;
   logic [CW-1:0] rd_cnt;

   int checks = 0;
   int errors = 0;

   typedef struct packed { int ang; int rho; int cnt; } exp_t;
   exp_t  exp_q[$];
   string cur_tag = "R1";
   bit    mon_busy = 1'b0;
   bit    img [H][W];
   int    seed = 32'h1234_5678;

   hough_grid_voter dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pix_valid_i(pv),
      .pix_edge_i(pe), .rd_ang_i(rd_ang), .rd_rho_i(rd_rho),
      .done_o(done), .rd_cnt_o(rd_cnt)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic check(bit ok, string req, int got, int expv, string what);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, got, expv);
      end
   endtask

   function automatic int q8(real v);
      real s;
      s = 256.0 * v;
      if (s >= 0.0) return $rtoi(s + 0.5);
      return -$rtoi(-s + 0.5);
   endfunction

   // expected vote space straight from the R3 formula, serial over the image
   task automatic push_expected();
      int acc [NA][NR];
      for (int a = 0; a < NA; a++)
         for (int b = 0; b < NR; b++) acc[a][b] = 0;
      for (int y = 0; y < H; y++)
         for (int x = 0; x < W; x++)
            if (img[y][x])
               for (int a = 0; a < NA; a++) begin
                  int c, s, r, b;
                  c = q8($cos(PI * a / NA));
                  s = q8($sin(PI * a / NA));
                  r = x * c + y * s + W * 256 + (1 << (7 + BL));
                  b = r / (1 << (8 + BL));
                  if (acc[a][b] < CMAX) acc[a][b]++;
               end
      for (int a = 0; a < NA; a++) begin
         for (int b = 0; b < NR; b++) exp_q.push_back('{a, b, acc[a][b]});
         for (int b = NR; b < 16; b++) exp_q.push_back('{a, b, 0}); // R9
      end
   endtask

   function automatic bit rnd_bit(int pct);
      seed = seed * 1103515245 + 12345;
      return ((seed >>> 8) & 32'h7fff) % 100 < pct;
   endfunction

   task automatic drive_frame(string tag, bit gaps, bit mid_start);
      cur_tag = tag;
      push_expected();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int n = 0; n < TW * TH; n++) begin
         int lx, ly;
         lx = n % TW;
         ly = n / TW;
         if (gaps) begin
            pv = 1'b0;
            pe = '1;  // R6: bubble beats carry junk that must not vote
            @(negedge clk);
         end
         pv = 1'b1;
         for (int t = 0; t < NT; t++)
            pe[t] = img[(t / GX) * TH + ly][(t % GX) * TW + lx];
         start = mid_start && (n == 1);
         @(negedge clk);
      end
      pv = 1'b0;
      pe = '0;
      check(done == 1'b0, "R7", int'(done), 0, "done one cycle after last beat");
      start = mid_start; // R8: start during drain
      @(negedge clk);
      start = 1'b0;
      check(done == 1'b1, "R7", int'(done), 1, "done two cycles after last beat");
      @(negedge clk);
      check(done == 1'b0, "R7", int'(done), 0, "done pulse width");
      wait (exp_q.size() == 0 && !mon_busy);
   endtask

   // monitor: pops expected bins after done and compares the read port
   initial begin
      forever begin
         @(posedge done);
         mon_busy = 1'b1;
         while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            @(negedge clk);
            rd_ang = 2'(e.ang);
            rd_rho = 4'(e.rho);
            #(CLK_PERIOD / 4);
            check(int'(rd_cnt) == e.cnt, cur_tag, int'(rd_cnt), e.cnt,
                  $sformatf("angle %0d bin %0d", e.ang, e.rho));
         end
         mon_busy = 1'b0;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(done == 1'b0, "R1", int'(done), 0, "done during reset");
      rst_n = 1'b1;
      @(negedge clk);
      // R6: beats offered with no open frame
      pv = 1'b1;
      pe = '1;
      repeat (3) @(negedge clk);
      pv = 1'b0;
      pe = '0;
      for (int a = 0; a < NA; a++)
         for (int b = 0; b < NR; b += 3) begin
            rd_ang = 2'(a);
            rd_rho = 4'(b);
            #(CLK_PERIOD / 4);
            check(rd_cnt == '0, "R1", int'(rd_cnt), 0, "bin after reset and idle beats");
         end
      check(done == 1'b0, "R1", int'(done), 0, "done after reset");

      for (int y = 0; y < H; y++) for (int x = 0; x < W; x++) img[y][x] = 1'b0;
      drive_frame("R2 empty image", 1'b0, 1'b0);

      img[9][5] = 1'b1;
      drive_frame("R2/R3 single pixel", 1'b0, 1'b0);

      for (int y = 0; y < H; y++) for (int x = 0; x < W; x++) img[y][x] = (x == y);
      drive_frame("R3/R4 diagonal line", 1'b0, 1'b0);

      for (int y = 0; y < H; y++) for (int x = 0; x < W; x++) img[y][x] = rnd_bit(30);
      drive_frame("R3 sparse random", 1'b0, 1'b0);

      for (int y = 0; y < H; y++) for (int x = 0; x < W; x++) img[y][x] = 1'b1;
      drive_frame("R4/R5 full image", 1'b1, 1'b0);

      for (int y = 0; y < H; y++) for (int x = 0; x < W; x++) img[y][x] = rnd_bit(60);
      drive_frame("R6 random with bubbles", 1'b1, 1'b0);

      for (int y = 0; y < H; y++) for (int x = 0; x < W; x++) img[y][x] = rnd_bit(45);
      drive_frame("R8 start while busy", 1'b0, 1'b1);

      for (int y = 0; y < H; y++) for (int x = 0; x < W; x++) img[y][x] = (y == 3) || (x == 12);
      drive_frame("R3/R5 row and column", 1'b0, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule